// File: doc/BRIEF.md
# Clock Source Switching Sequencer

This block walks a system off its 32.768 kHz low-power reference clock and onto a fast master clock derived from a PLL. After a start request it turns on the main crystal oscillator, programs the PLL, sets the master-clock prescaler and the processor divider while the slow source is still selected, and only then moves the source select onto the PLL. Each step ends only when its status flag comes back. The control values appear as parallel output fields, which a clock-control register block or the analog macros consume directly.

Every wait has a programmable timeout. If a flag does not arrive in time, the sequencer drops into an error state. That state returns every control field to its reset value, so the slow clock stays selected. A later start request retries the whole sequence. With an 18.432 MHz oscillator, a multiplier of 43, a master divider of 6 and a processor divider of 2, the result is about 396 MHz for the processor and 132 MHz for the master clock. The master clock is kept at or below 133 MHz.

The states are IDLE, OSC_WAIT, PLL_WAIT, DIV_WAIT, SRC_WAIT, RUN and ERR. The transitions are:
- start: IDLE to OSC_WAIT, and ERR to OSC_WAIT.
- osc_ok: OSC_WAIT to PLL_WAIT.
- lock_ok: PLL_WAIT to DIV_WAIT.
- div_ok: DIV_WAIT to SRC_WAIT.
- src_ok: SRC_WAIT to RUN.
- timeout: any wait state to ERR.

Top module: `clk_switch_seq`

## Requirements
- R1: After reset the outputs are: `osc_en_o`=0, `pll_mul_o`=0, `pll_byp_o`=0, `mck_div_o`=1, `cpu_div_o`=1, `src_sel_o`=0 (slow clock), `busy_o`=0, `done_o`=0, `err_o`=0.
- R2: A start request in IDLE enters OSC_WAIT at the next edge. OSC_WAIT drives `osc_en_o`=1 and `busy_o`=1 and waits for oscillator-stable on status bit 0.
- R3: After osc_ok, PLL_WAIT drives `pll_mul_o`=43 and `pll_byp_o`=1 (divider bypassed) and waits for PLL-locked on status bit 1.
- R4: After lock_ok, DIV_WAIT drives `mck_div_o`=6 and `cpu_div_o`=2 while `src_sel_o` stays 0. It waits for master-clock-ready on status bit 3.
- R5: After div_ok, SRC_WAIT drives `src_sel_o`=2 (PLL) and waits for status bit 3 again. In every wait, a flag sampled during the first cycle of the state is disregarded.
- R6: After src_ok, the block enters RUN. `done_o` is high for exactly one cycle, `busy_o` is 0 and the PLL stays selected.
- R7: The status input is registered once. A wait entered at edge E whose flag rises d cycles later (d ≥ 1) advances at edge E+d+2 when d < `timeout_i`. Otherwise it enters ERR at edge E+`timeout_i`+1.
- R8: In ERR, `err_o`=1, `busy_o`=0, and all control fields hold their reset values (slow clock, oscillator off) until a start request.
- R9: A start request in any wait state or in RUN is ignored. The step timing and outputs are unchanged.
- R10: A start request in ERR restarts the sequence at OSC_WAIT.
- R11: `src_sel_o` moves to the PLL only at an edge where the registered master-clock-ready flag was high.
- R12: With the defaults, the output fields give an 18.432 MHz oscillator × `pll_mul_o` / `mck_div_o` ≤ 133 MHz. The processor clock (before `cpu_div_o`) is 792.576 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, level sampled each cycle |
| timeout_i | input | TMO_W | Timeout length per wait, in cycles |
| status_i | input | 4 | Bit 0 oscillator stable, bit 1 PLL locked, bit 3 master clock ready; bit 2 unused |
| osc_en_o | output | 1 | Main oscillator enable |
| pll_mul_o | output | MUL_W | PLL multiplier field (0 = PLL off) |
| pll_byp_o | output | 1 | PLL input divider bypass |
| mck_div_o | output | MDIV_W | Master clock prescaler divide value |
| cpu_div_o | output | CDIV_W | Processor clock divide value |
| src_sel_o | output | 2 | Master clock source: 0 slow, 2 PLL |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout error state |

## Verification
The status flags come from delayed models. Each model restarts its delay whenever the control field it watches changes, and the master-clock-ready model drops its flag at once. A ready flag that is still high from the previous step therefore exposes any wait that fails to ignore its first cycle. Random delays and timeouts, checked one cycle before and at each predicted exit edge, separate correct step latency from off-by-one exits. They also separate a timeout into ERR from a normal advance. The directed cases cover the following:
- a delay one below the timeout, and a delay equal to it;
- a retry from ERR;
- start pulses scattered through busy periods and RUN, to show they change neither timing nor outputs.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_OSC_WAIT = 3'd1,
        ST_PLL_WAIT = 3'd2,
        ST_DIV_WAIT = 3'd3,
        ST_SRC_WAIT = 3'd4,
        ST_RUN      = 3'd5,
        ST_ERR      = 3'd6
    } seq_state_e;

    localparam logic [1:0] SRC_SLOW = 2'd0;
    localparam logic [1:0] SRC_PLL  = 2'd2;

    localparam int STAT_W    = 4;
    localparam int BIT_OSC   = 0;
    localparam int BIT_LOCK  = 1;
    localparam int BIT_MRDY  = 3;

    function automatic logic is_wait(seq_state_e s);
        return (s == ST_OSC_WAIT) || (s == ST_PLL_WAIT) ||
               (s == ST_DIV_WAIT) || (s == ST_SRC_WAIT);
    endfunction

endpackage

// File: rtl/clksw_status_reg.sv
module clksw_status_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] held_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) held_o[g] <= 1'b0;
            else        held_o[g] <= raw_i[g];
        end
    end
endmodule

// File: rtl/clksw_wait_timer.sv
module clksw_wait_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             armed_o,
    output logic             expired_o
);
    logic [TMO_W-1:0] cnt_q;

    assign armed_o   = (cnt_q != '0);
    assign expired_o = (cnt_q >= limit_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (restart_i)  cnt_q <= '0;
        else if (!expired_o) cnt_q <= cnt_q + 1'b1;
    end

    // R7: the count never leaves zero while the timer is being restarted
    a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !armed_o);
endmodule

// File: rtl/clk_switch_seq.sv
module clk_switch_seq
    import clksw_pkg::*;
#(
    parameter int TMO_W       = 8,
    parameter int MUL_W       = 8,
    parameter int MDIV_W      = 4,
    parameter int CDIV_W      = 2,
    parameter int PLL_MUL     = 43,
    parameter int MCK_DIV     = 6,
    parameter int CPU_DIV     = 2,
    parameter int OSC_KHZ     = 18432,
    parameter int MCK_MAX_KHZ = 133000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TMO_W-1:0]  timeout_i,
    input  logic [3:0]        status_i,
    output logic              osc_en_o,
    output logic [MUL_W-1:0]  pll_mul_o,
    output logic              pll_byp_o,
    output logic [MDIV_W-1:0] mck_div_o,
    output logic [CDIV_W-1:0] cpu_div_o,
    output logic [1:0]        src_sel_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int PLL_KHZ = OSC_KHZ * PLL_MUL;
    localparam int MCK_KHZ = PLL_KHZ / MCK_DIV;

    // R12: the derived master clock must stay inside its limit
    initial begin : g_freq_check
        a_r12_mck_limit: assert (MCK_KHZ <= MCK_MAX_KHZ)
            else $error("master clock %0d kHz above limit", MCK_KHZ);
    end

    seq_state_e        state_q, state_d;
    logic [STAT_W-1:0] stat_q;
    logic              flag_sel;
    logic              tmr_armed, tmr_expired;
    logic              done_q;
    logic              unused_stat;

    assign unused_stat = stat_q[2];

    clksw_status_reg #(.WIDTH(STAT_W)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (status_i),
        .held_o (stat_q)
    );

    clksw_wait_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (state_d != state_q),
        .limit_i   (timeout_i),
        .armed_o   (tmr_armed),
        .expired_o (tmr_expired)
    );

    // flag watched by the current wait state
    always_comb begin
        unique case (state_q)
            ST_OSC_WAIT: flag_sel = stat_q[BIT_OSC];
            ST_PLL_WAIT: flag_sel = stat_q[BIT_LOCK];
            ST_DIV_WAIT,
            ST_SRC_WAIT: flag_sel = stat_q[BIT_MRDY];
            default:     flag_sel = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_ERR: if (start_i) state_d = ST_OSC_WAIT;
            ST_OSC_WAIT: begin
                if (tmr_armed && flag_sel) state_d = ST_PLL_WAIT;
                else if (tmr_expired)      state_d = ST_ERR;
            end
            ST_PLL_WAIT: begin
                if (tmr_armed && flag_sel) state_d = ST_DIV_WAIT;
                else if (tmr_expired)      state_d = ST_ERR;
            end
            ST_DIV_WAIT: begin
                if (tmr_armed && flag_sel) state_d = ST_SRC_WAIT;
                else if (tmr_expired)      state_d = ST_ERR;
            end
            ST_SRC_WAIT: begin
                if (tmr_armed && flag_sel) state_d = ST_RUN;
                else if (tmr_expired)      state_d = ST_ERR;
            end
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_ERR;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_SRC_WAIT) && (state_d == ST_RUN);
        end
    end

    // outputs decoded from state
    always_comb begin
        osc_en_o  = 1'b0;
        pll_mul_o = '0;
        pll_byp_o = 1'b0;
        mck_div_o = MDIV_W'(1);
        cpu_div_o = CDIV_W'(1);
        src_sel_o = SRC_SLOW;
        unique case (state_q)
            ST_IDLE, ST_ERR: ;
            ST_OSC_WAIT: osc_en_o = 1'b1;
            ST_PLL_WAIT: begin
                osc_en_o  = 1'b1;
                pll_mul_o = MUL_W'(PLL_MUL);
                pll_byp_o = 1'b1;
            end
            ST_DIV_WAIT: begin
                osc_en_o  = 1'b1;
                pll_mul_o = MUL_W'(PLL_MUL);
                pll_byp_o = 1'b1;
                mck_div_o = MDIV_W'(MCK_DIV);
                cpu_div_o = CDIV_W'(CPU_DIV);
            end
            ST_SRC_WAIT, ST_RUN: begin
                osc_en_o  = 1'b1;
                pll_mul_o = MUL_W'(PLL_MUL);
                pll_byp_o = 1'b1;
                mck_div_o = MDIV_W'(MCK_DIV);
                cpu_div_o = CDIV_W'(CPU_DIV);
                src_sel_o = SRC_PLL;
            end
            default: ;
        endcase
    end

    assign busy_o = is_wait(state_q);
    assign err_o  = (state_q == ST_ERR);
    assign done_o = done_q;

    // R6: completion pulse lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11: source moves to the PLL only after ready was observed
    a_r11_src_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_sel_o) == SRC_SLOW && src_sel_o == SRC_PLL) |-> $past(stat_q[BIT_MRDY]));

    // R2: oscillator enable rises only in response to a start request
    a_r2_osc_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en_o) |-> $past(start_i));

    // R9: a start request while busy never restarts the sequence
    a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && state_q != ST_OSC_WAIT) |=> state_q != ST_OSC_WAIT);

    // R4: dividers are set before the source leaves the slow clock
    a_r4_div_before_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_sel_o == SRC_PLL) |-> $past(mck_div_o) == MDIV_W'(MCK_DIV));
endmodule

// File: tb/tb_clk_switch_seq.sv
module tb_clk_switch_seq;
    localparam int TMO_W = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] timeout_i = 8'd10;
    logic [3:0] status_i;
    logic       osc_en_o, pll_byp_o, busy_o, done_o, err_o;
    logic [7:0] pll_mul_o;
    logic [3:0] mck_div_o;
    logic [1:0] cpu_div_o, src_sel_o;

    always #10 clk = ~clk;

    clk_switch_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .timeout_i(timeout_i),
        .status_i(status_i), .osc_en_o(osc_en_o), .pll_mul_o(pll_mul_o),
        .pll_byp_o(pll_byp_o), .mck_div_o(mck_div_o), .cpu_div_o(cpu_div_o),
        .src_sel_o(src_sel_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    int checks = 0;
    int fails  = 0;
    int d_osc = 3, d_pll = 3, d_div = 3, d_src = 3;

    // delayed status flag models
    logic st_osc, st_lock, st_rdy, junk;
    int   c_osc, c_pll, c_mck;
    logic prev_osc, prev_pll;
    logic [7:0] prev_key;
    assign status_i = {st_rdy, junk, st_lock, st_osc};

    always @(negedge clk) begin
        if (!rst_n) begin
            st_osc = 0; st_lock = 0; st_rdy = 1; junk = 0;
            c_osc = 0; c_pll = 0; c_mck = 0;
            prev_osc = 0; prev_pll = 0; prev_key = {4'd1, 2'd1, 2'd0};
        end else begin
            junk = ~junk;
            if (!osc_en_o) begin st_osc = 0; c_osc = 0; end
            else if (!prev_osc) c_osc = d_osc;
            else if (c_osc > 0) begin c_osc--; if (c_osc == 0) st_osc = 1; end
            prev_osc = osc_en_o;
            if (pll_mul_o == 0) begin st_lock = 0; c_pll = 0; end
            else if (!prev_pll) c_pll = d_pll;
            else if (c_pll > 0) begin c_pll--; if (c_pll == 0) st_lock = 1; end
            prev_pll = (pll_mul_o != 0);
            if ({mck_div_o, cpu_div_o, src_sel_o} != prev_key) begin
                st_rdy = 0;
                c_mck = (src_sel_o == 2'd0) ? d_div : d_src;
            end else if (c_mck > 0) begin
                c_mck--; if (c_mck == 0) st_rdy = 1;
            end
            prev_key = {mck_div_o, cpu_div_o, src_sel_o};
        end
    end

    // expected output vector per step: 0..3 waits, 4 RUN, 5 ERR, 6 IDLE
    function automatic logic [19:0] exp_vec(int step);
        logic [19:0] v;
        v = {1'b0, 8'd0, 1'b0, 4'd1, 2'd1, 2'd0, 1'b0, 1'b0};
        if (step <= 4) begin
            v[19] = 1'b1;
            if (step >= 1) begin v[18:11] = 8'd43; v[10] = 1'b1; end
            if (step >= 2) begin v[9:6] = 4'd6; v[5:4] = 2'd2; end
            if (step >= 3) v[3:2] = 2'd2;
            v[1] = (step != 4);
        end else if (step == 5) v[0] = 1'b1;
        return v;
    endfunction

    function automatic logic [19:0] act_vec();
        return {osc_en_o, pll_mul_o, pll_byp_o, mck_div_o, cpu_div_o, src_sel_o, busy_o, err_o};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; start_i = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {12'd0, act_vec()}, {12'd0, exp_vec(6)});
        chk("R1 reset done", {31'd0, done_o}, 32'd0);
        rst_n = 1;
        @(negedge clk);
    endtask

    // runs a sequence from IDLE or ERR; returns 1 when RUN is reached
    task automatic run_seq(int a, int b, int c, int e, int tmo, output bit ok);
        int ds[4];
        ds[0] = a; ds[1] = b; ds[2] = c; ds[3] = e;
        d_osc = a; d_pll = b; d_div = c; d_src = e;
        timeout_i = 8'(tmo);
        ok = 0;
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        chk("R2 oscillator step", {12'd0, act_vec()}, {12'd0, exp_vec(0)});
        for (int s = 0; s < 4; s++) begin
            bit pass;
            int len;
            pass = ds[s] < tmo;
            len  = pass ? ds[s] + 2 : tmo + 1;
            for (int k = 1; k <= len; k++) begin
                @(negedge clk);
                start_i = (k < len) ? 1'($urandom % 2) : 1'b0; // R9 stray starts
                if (k == len - 1)
                    chk("R9 R7 still waiting", {12'd0, act_vec()}, {12'd0, exp_vec(s)});
            end
            if (!pass) begin
                chk("R7 R8 timeout to error", {12'd0, act_vec()}, {12'd0, exp_vec(5)});
                return;
            end
            if (s == 0) chk("R3 PLL step", {12'd0, act_vec()}, {12'd0, exp_vec(1)});
            if (s == 1) chk("R4 divider step", {12'd0, act_vec()}, {12'd0, exp_vec(2)});
            if (s == 2) chk("R5 source step", {12'd0, act_vec()}, {12'd0, exp_vec(3)});
            if (s == 3) begin
                chk("R6 run outputs", {12'd0, act_vec()}, {12'd0, exp_vec(4)});
                chk("R6 done pulse", {31'd0, done_o}, 32'd1);
            end
        end
        @(negedge clk);
        chk("R6 done one cycle", {31'd0, done_o}, 32'd0);
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        @(negedge clk);
        chk("R9 start in RUN ignored", {11'd0, done_o, act_vec()}, {12'd0, exp_vec(4)});
        chk("R12 master clock kHz", (32'd18432 * pll_mul_o) / mck_div_o <= 32'd133000, 32'd1);
        chk("R12 pll kHz", 32'd18432 * pll_mul_o, 32'd792576);
        ok = 1;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit ok;
        void'($urandom(32'd2024));
        do_reset();
        run_seq(3, 3, 3, 3, 10, ok);
        chk("R6 nominal completes", {31'd0, ok}, 32'd1);

        do_reset();
        run_seq(9, 2, 2, 2, 10, ok);
        chk("R7 delay one below timeout", {31'd0, ok}, 32'd1);

        do_reset();
        run_seq(10, 2, 2, 2, 10, ok);
        chk("R7 delay equal timeout", {31'd0, ok}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R8 error holds slow clock", {12'd0, act_vec()}, {12'd0, exp_vec(5)});

        do_reset();
        run_seq(2, 8, 2, 2, 6, ok);
        chk("R7 PLL lock timeout", {31'd0, ok}, 32'd0);
        repeat (4) @(negedge clk);
        run_seq(2, 2, 2, 2, 6, ok);
        chk("R10 retry from error", {31'd0, ok}, 32'd1);

        do_reset();
        run_seq(2, 2, 7, 2, 6, ok);
        chk("R5 divider-ready timeout", {31'd0, ok}, 32'd0);
        repeat (12) @(negedge clk);
        run_seq(2, 2, 2, 3, 6, ok);
        chk("R10 retry after divider error", {31'd0, ok}, 32'd1);

        for (int i = 0; i < 24; i++) begin
            int t, a, b, c, e;
            bit exp_ok;
            t = 4 + int'($urandom % 12);
            a = 1 + int'($urandom % 14);
            b = 1 + int'($urandom % 14);
            c = 1 + int'($urandom % 14);
            e = 1 + int'($urandom % 14);
            exp_ok = (a < t) && (b < t) && (c < t) && (e < t);
            do_reset();
            run_seq(a, b, c, e, t, ok);
            chk("R7 random outcome", {31'd0, ok}, {31'd0, exp_ok});
        end

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule